// File: doc/BRIEF.md
# Safety Error Status Aggregator

This block gathers single-cycle error pulses from three protected areas of a network controller: the MAC datapath and its state machines, the transmit/receive queue memories, and the DMA segmentation-offload memory. Each pulse is latched into a sticky status register for its area. Software clears these bits by writing ones to them.

From the latched bits the block derives read-only summary registers. It also classes each error as correctable or uncorrectable and drives a single interrupt line. Control registers hold per-memory ECC enables, per-memory correctable-interrupt enables, and the state-machine parity and timeout enables. Error detection and error counting are done elsewhere.

Register word addresses are 0 for MAC status, 1 for queue status, 2 for DMA status, 3 for the queue summary, 4 for the DMA summary, 5 for control and 6 for the interrupt enables. Reads are combinational from the address. Writes take effect at the clock edge where the write enable is high.

Top module: `safety_err_agg`

## Requirements
- R1: After reset every status register, summary register and control register reads zero, and `irq_o` is low.
- R2: A pulse on `mac_err_i` bit b sets MAC status bit b. Bits 0-7 are always latched. Bits 8-19 are latched when the timeout enable is set, and bit 24 when the parity enable is set. All other MAC status bits read zero.
- R3: The queue-memory status register holds one triplet per memory m, with m = 0 TX, 1 RX, 2 scheduler, 3 RX parser. Bit 4m is correctable, bit 4m+1 is address mismatch and bit 4m+2 is uncorrectable. A triplet is latched from `qmem_err_i` only while ECC enable bit m is set. Bits 4m+3 and bits 16-31 read zero.
- R4: DMA status bits 0-2 hold the correctable, address-mismatch and uncorrectable triplet. They latch from `dma_err_i` only while control bit 4 is set. All other bits read zero.
- R5: Writing a status register clears exactly the bits written as one. Bits written as zero keep their value.
- R6: An error pulse in the same cycle as a clearing write to its bit wins, and the bit stays set.
- R7: Queue summary (address 3) has three bits. Bit 0 is set by any MAC status bit. Bit 1 is set by any queue correctable bit. Bit 2 is set by any queue address-mismatch or uncorrectable bit.
- R8: DMA summary (address 4) has five bits. Bit 0 is the MAC summary. Bits 1 and 2 mirror queue correctable and queue uncorrectable. Bit 3 is DMA correctable, and bit 4 is DMA address mismatch or uncorrectable. Summaries drop as soon as the detail bits are cleared.
- R9: `irq_o` is high while any MAC bit, address-mismatch bit or uncorrectable bit is set. A correctable bit raises `irq_o` only when its interrupt enable is set: address 6 bit m for queue memory m, bit 4 for DMA.
- R10: Control (address 5) keeps ECC enables in bits 4:0, parity enable in bit 8 and timeout enable in bit 9. Interrupt enables (address 6) use bits 4:0. Both read back what was written, and unused bits read zero.
- R11: While the timeout or parity enable is clear, pulses on the MAC bits it gates leave status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mac_err_i | input | 32 | MAC error pulses, one per status bit |
| qmem_err_i | input | 16 | Queue-memory error pulses, laid out as the queue status |
| dma_err_i | input | 3 | DMA memory error pulses (correctable, mismatch, uncorrectable) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Safety interrupt |

## Verification
The two functions that can fall in the same cycle are a software clearing write to a status bit and a fresh error pulse on that same bit. The bench provokes this by driving the write strobe and the pulse together in one cycle. In one case the pulse hits a bit being cleared; in another, a bit beside it is cleared. The result is judged by reading the register back: a pulsed bit must survive, while the other written bits must fall.

// File: rtl/safety_agg_pkg.sv
package safety_agg_pkg;
    parameter int DW     = 32;
    parameter int AW     = 3;
    parameter int NQMEM  = 4;
    localparam int QW    = 4 * NQMEM;
    localparam int NEN   = NQMEM + 1;

    localparam logic [DW-1:0] MAC_DP_MASK  = 32'h0000_00FF;
    localparam logic [DW-1:0] MAC_TMO_MASK = 32'h000F_FF00;
    localparam logic [DW-1:0] MAC_PAR_MASK = 32'h0100_0000;
    localparam logic [DW-1:0] MAC_MASK     = MAC_DP_MASK | MAC_TMO_MASK | MAC_PAR_MASK;

    localparam logic [AW-1:0] A_MAC  = 3'd0;
    localparam logic [AW-1:0] A_QST  = 3'd1;
    localparam logic [AW-1:0] A_DST  = 3'd2;
    localparam logic [AW-1:0] A_QSUM = 3'd3;
    localparam logic [AW-1:0] A_DSUM = 3'd4;
    localparam logic [AW-1:0] A_CTRL = 3'd5;
    localparam logic [AW-1:0] A_CIE  = 3'd6;

    typedef struct packed {
        logic           tmo_en;
        logic           par_en;
        logic [NEN-1:0] ecc_en;
        logic [NEN-1:0] cie;
    } ctrl_t;
endpackage

// File: rtl/err_latch.sv
module err_latch #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    // set after clear, so a pulse in a clearing cycle survives
    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr_i) | (set_i & en_i & MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/err_summary.sv
module err_summary
    import safety_agg_pkg::*;
(
    input  logic [DW-1:0]      mac_stat_i,
    input  logic [3*NQMEM-1:0] q_trip_i,
    input  logic [2:0]         dma_stat_i,
    input  logic [NEN-1:0]     cie_i,
    output logic [2:0]         qsum_o,
    output logic [4:0]         dsum_o,
    output logic               irq_o
);
    logic [NQMEM-1:0] q_corr, q_unc;
    logic [NEN-1:0]   corr_irq;
    logic             mac_any, d_corr, d_unc;

    for (genvar m = 0; m < NQMEM; m++) begin : g_mem
        assign q_corr[m]   = q_trip_i[3*m];
        assign q_unc[m]    = q_trip_i[3*m+1] | q_trip_i[3*m+2];
        assign corr_irq[m] = q_corr[m] & cie_i[m];
    end

    assign d_corr          = dma_stat_i[0];
    assign d_unc           = dma_stat_i[1] | dma_stat_i[2];
    assign corr_irq[NQMEM] = d_corr & cie_i[NQMEM];
    assign mac_any         = |mac_stat_i;

    assign qsum_o = {|q_unc, |q_corr, mac_any};
    assign dsum_o = {d_unc, d_corr, |q_unc, |q_corr, mac_any};
    assign irq_o  = mac_any | (|q_unc) | d_unc | (|corr_irq);
endmodule

// File: rtl/safety_err_agg.sv
module safety_err_agg
    import safety_agg_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] mac_err_i,
    input  logic [QW-1:0] qmem_err_i,
    input  logic [2:0]    dma_err_i,
    input  logic          reg_we_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o
);
    ctrl_t ctrl_d, ctrl_q;

    logic [DW-1:0]      mac_en, mac_clr, mac_stat;
    logic [QW-1:0]      q_en, q_clr, q_stat;
    logic [2:0]         dma_clr, dma_stat;
    logic               dma_en;
    logic [3*NQMEM-1:0] q_trip;
    logic [2:0]         qsum;
    logic [4:0]         dsum;

    localparam logic [QW-1:0] Q_MASK = {NQMEM{4'b0111}};

    // write strobes and enables
    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we_i && reg_addr_i == A_CTRL) begin
            ctrl_d.ecc_en = reg_wdata_i[NEN-1:0];
            ctrl_d.par_en = reg_wdata_i[8];
            ctrl_d.tmo_en = reg_wdata_i[9];
        end
        if (reg_we_i && reg_addr_i == A_CIE) ctrl_d.cie = reg_wdata_i[NEN-1:0];

        mac_clr = (reg_we_i && reg_addr_i == A_MAC) ? reg_wdata_i : '0;
        q_clr   = (reg_we_i && reg_addr_i == A_QST) ? reg_wdata_i[QW-1:0] : '0;
        dma_clr = (reg_we_i && reg_addr_i == A_DST) ? reg_wdata_i[2:0] : '0;

        mac_en  = MAC_DP_MASK | ({DW{ctrl_q.tmo_en}} & MAC_TMO_MASK)
                              | ({DW{ctrl_q.par_en}} & MAC_PAR_MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    for (genvar m = 0; m < NQMEM; m++) begin : g_qen
        assign q_en[4*m +: 4]   = {4{ctrl_q.ecc_en[m]}};
        assign q_trip[3*m +: 3] = q_stat[4*m +: 3];
    end
    assign dma_en = ctrl_q.ecc_en[NQMEM];

    err_latch #(.W(DW), .MASK(MAC_MASK)) u_mac (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(mac_err_i),
        .en_i(mac_en), .clr_i(mac_clr), .stat_o(mac_stat));

    err_latch #(.W(QW), .MASK(Q_MASK)) u_qmem (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(qmem_err_i),
        .en_i(q_en), .clr_i(q_clr), .stat_o(q_stat));

    err_latch #(.W(3), .MASK(3'b111)) u_dma (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(dma_err_i),
        .en_i({3{dma_en}}), .clr_i(dma_clr), .stat_o(dma_stat));

    err_summary u_sum (
        .mac_stat_i(mac_stat), .q_trip_i(q_trip), .dma_stat_i(dma_stat),
        .cie_i(ctrl_q.cie), .qsum_o(qsum), .dsum_o(dsum), .irq_o(irq_o));

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_MAC:  reg_rdata_o = mac_stat;
            A_QST:  reg_rdata_o[QW-1:0] = q_stat;
            A_DST:  reg_rdata_o[2:0] = dma_stat;
            A_QSUM: reg_rdata_o[2:0] = qsum;
            A_DSUM: reg_rdata_o[4:0] = dsum;
            A_CTRL: begin
                reg_rdata_o[NEN-1:0] = ctrl_q.ecc_en;
                reg_rdata_o[8]       = ctrl_q.par_en;
                reg_rdata_o[9]       = ctrl_q.tmo_en;
            end
            A_CIE:  reg_rdata_o[NEN-1:0] = ctrl_q.cie;
            default: reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/safety_err_agg_chk.sv
module safety_err_agg_chk
    import safety_agg_pkg::*;
(
    input logic          clk_i,
    input logic          rst_ni,
    input logic [2:0]    dma_err_i,
    input logic          dma_en_i,
    input logic [2:0]    dma_clr_i,
    input logic [2:0]    dma_stat_i,
    input logic [DW-1:0] mac_stat_i,
    input logic [QW-1:0] q_stat_i,
    input logic          irq_i
);
    localparam logic [QW-1:0] QRSVD = {NQMEM{4'b1000}};

    AST_MAC_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mac_stat_i & ~MAC_MASK) == '0); // R2
    AST_Q_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_stat_i & QRSVD) == '0); // R3
    AST_PULSE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_en_i && dma_err_i[2] && dma_clr_i[2]) |=> dma_stat_i[2]); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_clr_i[2] && !(dma_en_i && dma_err_i[2])) |=> !dma_stat_i[2]); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_stat_i[2] && !dma_clr_i[2]) |=> dma_stat_i[2]); // R5
    AST_UNC_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|mac_stat_i) || dma_stat_i[2]) |-> irq_i); // R9
endmodule

bind safety_err_agg safety_err_agg_chk chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dma_err_i(dma_err_i), .dma_en_i(dma_en),
    .dma_clr_i(dma_clr), .dma_stat_i(dma_stat), .mac_stat_i(mac_stat),
    .q_stat_i(q_stat), .irq_i(irq_o));

// File: tb/safety_err_agg_tb_top.sv
`timescale 1ns/1ps
module safety_err_agg_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] mac_err_i = '0;
    logic [15:0] qmem_err_i = '0;
    logic [2:0]  dma_err_i = '0;
    logic        reg_we_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    safety_err_agg dut_i (.*);

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i); #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr_i = a; #0.5; v = reg_rdata_o;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic pulse(input logic [31:0] m, input logic [15:0] q, input logic [2:0] d);
        mac_err_i = m; qmem_err_i = q; dma_err_i = d;
        tick();
        mac_err_i = '0; qmem_err_i = '0; dma_err_i = '0;
    endtask

    task automatic rdchk(string req, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 7; a++) rdchk("R1", a[2:0], 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_gate();
        pulse(32'hFFFF_FFFF, 16'hFFFF, 3'b111);
        rdchk("R11 mac gated", 3'd0, 32'h0000_00FF);
        rdchk("R3 queue ecc off", 3'd1, 32'h0);
        rdchk("R4 dma ecc off", 3'd2, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        rdchk("R5 mac cleared", 3'd0, 32'h0);
    endtask

    task automatic t_ctrl();
        wr(3'd5, 32'hFFFF_FFFF);
        rdchk("R10 ctrl", 3'd5, 32'h0000_031F);
        wr(3'd6, 32'hFFFF_FFFF);
        rdchk("R10 cie", 3'd6, 32'h0000_001F);
        wr(3'd6, 32'h0);
        rdchk("R10 cie zero", 3'd6, 32'h0);
    endtask

    task automatic t_mac();
        pulse(32'hFFFF_FFFF, '0, '0);
        rdchk("R2 mac layout", 3'd0, 32'h010F_FFFF);
        chk("R9 mac irq", {31'b0, irq_o}, 32'h1);
        rdchk("R7 qsum mac", 3'd3, 32'h1);
        rdchk("R8 dsum mac", 3'd4, 32'h1);
        wr(3'd0, 32'hFFFF_FFFF);
        rdchk("R8 dsum drops", 3'd4, 32'h0);
    endtask

    task automatic t_queue();
        pulse('0, 16'hFFFF, '0);
        rdchk("R3 queue layout", 3'd1, 32'h0000_7777);
        rdchk("R7 qsum", 3'd3, 32'h6);
        rdchk("R8 dsum mirror", 3'd4, 32'h6);
        wr(3'd1, 32'hFFFF_FFFF);
        pulse('0, 16'h0100, '0);
        rdchk("R3 sched corr", 3'd1, 32'h0000_0100);
        rdchk("R7 qsum corr", 3'd3, 32'h2);
        chk("R9 corr masked", {31'b0, irq_o}, 32'h0);
        wr(3'd6, 32'h4);
        chk("R9 corr enabled", {31'b0, irq_o}, 32'h1);
        wr(3'd6, 32'h0);
        wr(3'd1, 32'h0000_0100);
        rdchk("R5 queue clear", 3'd1, 32'h0);
    endtask

    task automatic t_dma();
        pulse('0, '0, 3'b111);
        rdchk("R4 dma", 3'd2, 32'h7);
        rdchk("R8 dsum dma", 3'd4, 32'h18);
        chk("R9 dma unc irq", {31'b0, irq_o}, 32'h1);
        wr(3'd2, 32'h6);
        rdchk("R8 dsum corr only", 3'd4, 32'h08);
        chk("R9 dma corr masked", {31'b0, irq_o}, 32'h0);
        wr(3'd2, 32'h1);
        rdchk("R8 dsum clear", 3'd4, 32'h0);
    endtask

    task automatic t_w1c_collide();
        pulse('0, 16'h0077, '0);
        wr(3'd1, 32'h0000_0005);
        rdchk("R5 partial clear", 3'd1, 32'h0000_0072);
        qmem_err_i = 16'h0002;
        wr(3'd1, 32'h0000_0002);
        qmem_err_i = '0;
        rdchk("R6 pulse wins", 3'd1, 32'h0000_0072);
        qmem_err_i = 16'h0001;
        wr(3'd1, 32'h0000_0070);
        qmem_err_i = '0;
        rdchk("R6 neighbour", 3'd1, 32'h0000_0003);
        wr(3'd1, 32'hFFFF_FFFF);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1;
        t_reset();
        rst_ni = 1'b1;
        tick();
        t_reset();
        t_gate();
        t_ctrl();
        t_mac();
        t_queue();
        t_dma();
        t_w1c_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule